// File: doc/BRIEF.md
# Flash Command Sequencer with Boot-Region Lockout

This block is the control front end of a byte-wide flash storage array. The array is held in registers here. A host drives chip-select, output-enable and write-enable strobes with an address and a data byte. Plain reads return stored bytes. Multi-write command sequences start self-timed byte programs, a whole-array erase, a permanent lock of the low boot region, or entry into and exit from an identification mode. While a program or erase is in progress, every read returns a polling status on bit 7.

The array depth is 2^ADDR_W bytes. The boot region is the lowest 2^BOOT_W bytes. A full-size part uses ADDR_W=16 and BOOT_W=13. The defaults (ADDR_W=11, BOOT_W=8) keep the register array small. Command addresses are 5555h and 2AAAh truncated to ADDR_W bits, which gives 555h and 2AAh at the defaults. Program and erase durations are parameters counted in clock cycles. All strobes are active low and are sampled on the rising edge of `clk`. Read data is driven onto `dout` with `dout_en` as the drive enable.

Top module: `flash_seq_top`

## Requirements
- R1: `dout_en` is 1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1. In normal mode when not busy, `dout` then equals the byte stored at `addr`.
- R2: After reset, every byte reads FFh, the boot region is unlocked, identification mode is off and no operation is busy.
- R3: A byte program stores the bitwise AND of the old byte and the written data. Bits can only go from 1 to 0.
- R4: A byte program is four writes: AAh to 555h, 55h to 2AAh, A0h to 555h, then the data to the target address.
- R5: The six writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h erase every byte to FFh. The boot region is skipped when it is locked.
- R6: The same sequence ending in 40h@555h locks the boot region until reset. After that, programs to the boot region do nothing and start no busy period. Main-region bytes can still be programmed and erased.
- R7: AAh@555h, 55h@2AAh, 90h@555h enters identification mode, and ending with F0h instead exits it. In this mode, reads of address 0 return MFR_ID, address 1 returns DEV_ID, and address 2 returns 0000000b followed by the lock bit (bit 0 = 1 when locked).
- R8: A write takes its address when `ce_n` and `we_n` are first both low. It takes its data when either strobe rises. Address changes in the middle of a write have no effect.
- R9: A program is busy for PROG_CYCLES cycles and an erase for ERASE_CYCLES cycles. While busy, reads return bit 7 = inverse of the written bit 7 (program) or 0 (erase), with bits 6..0 = 0. Writes made while busy are ignored.
- R10: Any write that does not match the next expected step of a sequence returns the sequencer to idle, and no command is executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| dout_en | output | 1 | Read data drive enable |

## Verification
Directed programs check that a second program ANDs into the byte, and that the polling value appears right after the final write. A directed case also issues a complete second program while the first is busy, to tell apart gating writes during busy from accepting them. Seeded random programs to both regions, checked before and after the lock, separate correct boot gating from address decode faults. Broken unlock sequences, identification reads, and erases with and without the lock cover the mode and protection corners.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE, SQ_U1, SQ_U2, SQ_PROG, SQ_E3, SQ_E4, SQ_E5
    } seq_state_e;

    typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_ERASE} op_kind_e;

    localparam logic [15:0] CMD_ADDR_A = 16'h5555;
    localparam logic [15:0] CMD_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  KEY_1      = 8'hAA;
    localparam logic [7:0]  KEY_2      = 8'h55;
    localparam logic [7:0]  OPC_PROG   = 8'hA0;
    localparam logic [7:0]  OPC_EXT    = 8'h80;
    localparam logic [7:0]  OPC_IDIN   = 8'h90;
    localparam logic [7:0]  OPC_IDOUT  = 8'hF0;
    localparam logic [7:0]  OPC_ERASE  = 8'h10;
    localparam logic [7:0]  OPC_LOCK   = 8'h40;
endpackage

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              prog_go,
    output logic              erase_go,
    output logic              lock_go,
    output logic              id_mode
);
    typedef struct packed {
        seq_state_e state;
        logic       id_mode;
    } dec_s;

    dec_s q, d;
    logic at_a, at_b;

    assign at_a = (wr_addr == CMD_ADDR_A[ADDR_W-1:0]);
    assign at_b = (wr_addr == CMD_ADDR_B[ADDR_W-1:0]);

    always_comb begin
        d        = q;
        prog_go  = 1'b0;
        erase_go = 1'b0;
        lock_go  = 1'b0;
        if (wr_evt) begin
            d.state = SQ_IDLE;
            case (q.state)
                SQ_IDLE: if (at_a && wr_data == KEY_1) d.state = SQ_U1;
                SQ_U1:   if (at_b && wr_data == KEY_2) d.state = SQ_U2;
                SQ_U2: if (at_a) begin
                    case (wr_data)
                        OPC_PROG:  d.state   = SQ_PROG;
                        OPC_EXT:   d.state   = SQ_E3;
                        OPC_IDIN:  d.id_mode = 1'b1;
                        OPC_IDOUT: d.id_mode = 1'b0;
                        default:   d.state   = SQ_IDLE;
                    endcase
                end
                SQ_PROG: prog_go = 1'b1;
                SQ_E3:   if (at_a && wr_data == KEY_1) d.state = SQ_E4;
                SQ_E4:   if (at_b && wr_data == KEY_2) d.state = SQ_E5;
                SQ_E5: if (at_a) begin
                    erase_go = (wr_data == OPC_ERASE);
                    lock_go  = (wr_data == OPC_LOCK);
                end
                default: d.state = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state   <= SQ_IDLE;
            q.id_mode <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign id_mode = q.id_mode;

    // R10: from idle a single write can advance at most one step
    assert_one_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == SQ_IDLE) |=> (q.state == SQ_IDLE || q.state == SQ_U1));
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int PROG_CYCLES  = 24,
    parameter int ERASE_CYCLES = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_prog,
    input  logic              start_erase,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [7:0]        start_data,
    output logic              busy,
    output logic              poll_bit,
    output logic              commit_prog,
    output logic              commit_erase,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data
);
    localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        op_kind_e          kind;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } tmr_s;

    tmr_s q, d;

    always_comb begin
        d            = q;
        commit_prog  = 1'b0;
        commit_erase = 1'b0;
        if (q.kind == OP_NONE) begin
            if (start_prog) begin
                d.kind = OP_PROG;
                d.cnt  = CNT_W'(PROG_CYCLES - 1);
                d.addr = start_addr;
                d.data = start_data;
            end else if (start_erase) begin
                d.kind = OP_ERASE;
                d.cnt  = CNT_W'(ERASE_CYCLES - 1);
            end
        end else if (q.cnt == '0) begin
            commit_prog  = (q.kind == OP_PROG);
            commit_erase = (q.kind == OP_ERASE);
            d.kind       = OP_NONE;
        end else begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{kind: OP_NONE, cnt: '0, addr: '0, data: '0};
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.kind != OP_NONE);
    assign poll_bit = (q.kind == OP_PROG) ? ~q.data[7] : 1'b0;
    assign op_addr  = q.addr;
    assign op_data  = q.data;

    // R9: the command front end never launches work while an operation runs
    assert_no_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(start_prog || start_erase));
endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array #(
    parameter int ADDR_W = 11,
    parameter int BOOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_prog,
    input  logic              commit_erase,
    input  logic              lock_set,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              locked
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int BOOT_BYTES = 1 << BOOT_W;

    logic [7:0] mem_q [DEPTH];
    logic [7:0] mem_d [DEPTH];
    logic       lock_q, lock_d;

    always_comb begin
        mem_d  = mem_q;
        lock_d = lock_q | lock_set;
        if (commit_prog) begin
            mem_d[wr_addr] = mem_q[wr_addr] & wr_data;
        end
        if (commit_erase) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!(lock_q && i < BOOT_BYTES)) mem_d[i] = 8'hFF;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
            lock_q <= 1'b0;
        end else begin
            mem_q  <= mem_d;
            lock_q <= lock_d;
        end
    end

    assign rd_data = mem_q[rd_addr];
    assign locked  = lock_q;

    // R3: a committed program leaves old AND new in the byte
    assert_prog_and_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_prog |=> mem_q[$past(wr_addr)] == ($past(mem_q[wr_addr]) & $past(wr_data)));
    // R6: the lock never clears once set
    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);
    // R6: no program reaches a locked boot byte
    assert_boot_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_prog && lock_q && wr_addr[ADDR_W-1:BOOT_W] == '0));
    // R5: the top byte of main memory is blank after an erase
    assert_erase_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_erase |=> mem_q[DEPTH-1] == 8'hFF);
endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top #(
    parameter int          ADDR_W       = 11,
    parameter int          BOOT_W       = 8,
    parameter int          PROG_CYCLES  = 24,
    parameter int          ERASE_CYCLES = 80,
    parameter logic [7:0]  MFR_ID       = 8'hA5,
    parameter logic [7:0]  DEV_ID       = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en
);
    typedef struct packed {
        logic              strobe;
        logic [ADDR_W-1:0] addr_lat;
    } bus_s;

    bus_s q, d;
    logic strobe_now, wr_evt, busy, poll_bit, locked, id_mode;
    logic prog_go, prog_ok, erase_go, lock_go, commit_prog, commit_erase;
    logic [ADDR_W-1:0] op_addr;
    logic [7:0] op_data, rd_data;

    assign strobe_now = ~ce_n & ~we_n;

    always_comb begin
        d        = q;
        d.strobe = strobe_now;
        if (strobe_now && !q.strobe) d.addr_lat = addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{strobe: 1'b0, addr_lat: '0};
        end else begin
            q <= d;
        end
    end

    assign wr_evt  = q.strobe & ~strobe_now & ~busy;
    assign prog_ok = prog_go & ~(locked && q.addr_lat[ADDR_W-1:BOOT_W] == '0);

    flash_cmd_decoder #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_addr(q.addr_lat),
        .wr_data(din), .prog_go(prog_go), .erase_go(erase_go),
        .lock_go(lock_go), .id_mode(id_mode)
    );

    flash_op_timer #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES),
                     .ERASE_CYCLES(ERASE_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start_prog(prog_ok), .start_erase(erase_go),
        .start_addr(q.addr_lat), .start_data(din), .busy(busy),
        .poll_bit(poll_bit), .commit_prog(commit_prog),
        .commit_erase(commit_erase), .op_addr(op_addr), .op_data(op_data)
    );

    flash_byte_array #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .commit_prog(commit_prog),
        .commit_erase(commit_erase), .lock_set(lock_go), .wr_addr(op_addr),
        .wr_data(op_data), .rd_addr(addr), .rd_data(rd_data), .locked(locked)
    );

    always_comb begin
        if (busy) begin
            dout = {poll_bit, 7'b0};
        end else if (id_mode) begin
            if (addr == ADDR_W'(0))      dout = MFR_ID;
            else if (addr == ADDR_W'(1)) dout = DEV_ID;
            else if (addr == ADDR_W'(2)) dout = {7'b0, locked};
            else                         dout = 8'h00;
        end else begin
            dout = rd_data;
        end
    end

    assign dout_en = ~ce_n & ~oe_n & we_n;

    // R9: erase polling reads return zero on bit 7
    assert_erase_poll_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !poll_bit) |-> dout == 8'h00);
endmodule

// File: tb/tb_flash_seq_top.sv
module tb_flash_seq_top;
    localparam int AW    = 11;
    localparam int DEPTH = 1 << AW;
    localparam int BOOTN = 256;
    localparam int PCYC  = 24;
    localparam int ECYC  = 80;
    localparam logic [AW-1:0] CA = 11'h555;
    localparam logic [AW-1:0] CB = 11'h2AA;

    logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1, we_n = 1;
    logic [AW-1:0] addr = '0;
    logic [7:0] din = '0, dout;
    logic dout_en;
    int checks = 0, errors = 0;
    logic [7:0] model [DEPTH];
    logic lock_m = 0;

    always #5 clk = ~clk;

    flash_seq_top dut (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en));

    function automatic logic is_boot(logic [AW-1:0] a);
        return int'(a) < BOOTN;
    endfunction

    task automatic check8(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic bus_write(logic [AW-1:0] a, logic [7:0] dv);
        @(negedge clk); addr = a; din = 8'h00; ce_n = 0; we_n = 0;
        @(negedge clk); addr = ~a; din = dv;   // R8: address moves mid-write
        @(negedge clk); ce_n = 1; we_n = 1;
        @(negedge clk); din = ~dv; addr = '0;
    endtask

    task automatic bus_read(logic [AW-1:0] a, output logic [7:0] dv, output logic en);
        @(negedge clk); addr = a; ce_n = 0; oe_n = 0;
        #2; dv = dout; en = dout_en;
        @(negedge clk); ce_n = 1; oe_n = 1;
    endtask

    task automatic read_check(string req, logic [AW-1:0] a, logic [7:0] exp);
        logic [7:0] v; logic en;
        bus_read(a, v, en);
        check8(req, {7'b0, en}, 8'h01);
        check8(req, v, exp);
    endtask

    task automatic unlock3(logic [7:0] opc);
        bus_write(CA, 8'hAA); bus_write(CB, 8'h55); bus_write(CA, opc);
    endtask

    task automatic seq_prog(logic [AW-1:0] a, logic [7:0] dv);
        unlock3(8'hA0); bus_write(a, dv);
    endtask

    task automatic cmd_prog(logic [AW-1:0] a, logic [7:0] dv);
        seq_prog(a, dv);
        if (!(lock_m && is_boot(a))) model[a] = model[a] & dv;
        repeat (PCYC + 3) @(negedge clk);
    endtask

    task automatic seq_ext(logic [7:0] last);
        unlock3(8'h80); bus_write(CA, 8'hAA); bus_write(CB, 8'h55); bus_write(CA, last);
    endtask

    task automatic model_erase();
        for (int i = 0; i < DEPTH; i++) if (!(lock_m && i < BOOTN)) model[i] = 8'hFF;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v; logic en;
        void'($urandom(32'd4242));
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk); rst_n = 1;

        // R2 reset state, R1 read enable
        read_check("R2 reset blank", 11'h000, 8'hFF);
        read_check("R2 reset blank", 11'h7FF, 8'hFF);
        read_check("R2 not in id mode", 11'h000, 8'hFF);
        @(negedge clk); addr = 11'h010; ce_n = 0; oe_n = 1; #2;
        check8("R1 oe_n high no drive", {7'b0, dout_en}, 8'h00);
        ce_n = 1; oe_n = 0; #2;
        check8("R1 ce_n high no drive", {7'b0, dout_en}, 8'h00);
        oe_n = 1;

        // R4/R9 program with polling, R3 AND behaviour
        seq_prog(11'h300, 8'h5A); model[11'h300] = 8'h5A;
        read_check("R9 program poll", 11'h300, 8'h80);
        repeat (PCYC + 3) @(negedge clk);
        read_check("R4 program result", 11'h300, 8'h5A);
        cmd_prog(11'h300, 8'h0F);
        read_check("R3 AND of old and new", 11'h300, 8'h0A);
        cmd_prog(11'h300, 8'hFF);
        read_check("R3 cannot set bits", 11'h300, 8'h0A);

        // R9 writes during busy ignored
        seq_prog(11'h400, 8'h81); model[11'h400] = 8'h81;
        read_check("R9 poll inverse bit7", 11'h400, 8'h00);
        seq_prog(11'h401, 8'h00);
        repeat (PCYC + 3) @(negedge clk);
        read_check("R9 busy write ignored", 11'h401, 8'hFF);
        read_check("R9 first program done", 11'h400, 8'h81);

        // R10 broken sequence
        bus_write(CA, 8'hAA); bus_write(CB, 8'h12); bus_write(CA, 8'hA0); bus_write(11'h500, 8'h00);
        repeat (PCYC + 3) @(negedge clk);
        read_check("R10 broken unlock", 11'h500, 8'hFF);
        bus_write(CA, 8'hAA); bus_write(11'h123, 8'h55); bus_write(CA, 8'hA0); bus_write(11'h501, 8'h00);
        repeat (PCYC + 3) @(negedge clk);
        read_check("R10 wrong address", 11'h501, 8'hFF);
        cmd_prog(11'h500, 8'h3C);
        read_check("R10 recovers to idle", 11'h500, 8'h3C);

        // random programs, both regions
        for (int k = 0; k < 40; k++) begin
            logic [AW-1:0] a = AW'($urandom);
            logic [7:0] dv = 8'($urandom);
            cmd_prog(a, dv);
            read_check("R3 random program", a, model[a]);
        end

        // R7 identification mode
        unlock3(8'h90);
        read_check("R7 maker code", 11'h000, 8'hA5);
        read_check("R7 device code", 11'h001, 8'h3C);
        read_check("R7 lock bit clear", 11'h002, 8'h00);
        unlock3(8'hF0);
        read_check("R7 exit to normal reads", 11'h300, model[11'h300]);

        // R5 erase unlocked
        seq_ext(8'h10); model_erase();
        read_check("R9 erase poll", 11'h300, 8'h00);
        repeat (ECYC + 3) @(negedge clk);
        read_check("R5 erase main", 11'h300, 8'hFF);
        read_check("R5 erase boot unlocked", 11'h000, 8'hFF);

        // R6 lockout
        cmd_prog(11'h010, 8'h33);
        seq_ext(8'h40); lock_m = 1;
        unlock3(8'h90);
        read_check("R6 R7 lock bit set", 11'h002, 8'h01);
        unlock3(8'hF0);
        seq_prog(11'h020, 8'h00);
        read_check("R6 boot program no busy", 11'h020, 8'hFF);
        cmd_prog(11'h010, 8'h00);
        read_check("R6 boot byte kept", 11'h010, 8'h33);
        cmd_prog(11'h700, 8'h44);
        read_check("R6 main still programmable", 11'h700, 8'h44);
        seq_ext(8'h10); model_erase();
        repeat (ECYC + 3) @(negedge clk);
        read_check("R5 R6 erase skips locked boot", 11'h010, 8'h33);
        read_check("R5 erase main after lock", 11'h700, 8'hFF);

        for (int k = 0; k < 30; k++) begin
            logic [AW-1:0] a = AW'($urandom);
            logic [7:0] dv = 8'($urandom);
            cmd_prog(a, dv);
            read_check("R6 random after lock", a, model[a]);
        end

        // R8 read back confirms address latched at strobe start
        bus_read(11'h010, v, en);
        check8("R8 address at strobe start", v, model[11'h010]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule